// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block sends words over a single data line while a device on the other end of the link supplies the shift clock. It never generates a clock of its own. The external clock is brought into the system clock domain through a short flop chain, and each selected edge of it moves the transmitter one bit forward. Because every shift depends only on that external clock, frames keep moving while the rest of the system sleeps.

Software, or any producer, writes a word into a one-entry holding stage. When the shifter is idle, the word moves straight into the shifter. When the shifter is busy, the word waits in the holding stage. A ready flag, with an enable that gates it onto an interrupt/wake line, shows when another word can be written. A status output shows when the shifter has no bits left to send. Frames are 8 bits long, or 9 bits when the ninth bit comes from a separate input that is latched together with the word.

Top module: `sync_slave_tx`

## Requirements
- R1: Transmission is active only when `port_en`=1, `sync_mode`=1, `clk_is_master`=0, `tx_en`=1, `rx_one_en`=0 and `rx_cont_en`=0. While it is inactive, external clock edges leave `ser_dout` and `shreg_empty` unchanged, writes are dropped, and `ready_flag` is 0.
- R2: A write (`wr_valid`=1 at a clock edge) to an empty holding stage fills that stage. On the next edge the word moves into an empty shifter: `shreg_empty` goes to 0 and `ser_dout` shows bit 0 of the word.
- R3: Bits leave least significant first. Each active external edge makes `ser_dout` show the next bit, 3 system clocks after the pin changes. The active edge that follows the last bit sets `shreg_empty`=1, and `ser_dout` keeps the last bit.
- R4: A word written while the shifter is busy waits in the holding stage, and `ready_flag` stays 0 meanwhile. A write while the holding stage is full is ignored.
- R5: `ready_flag` = 1 exactly when transmission is active and the holding stage is empty. A waiting word moves into the shifter one clock after the shifter empties, and `ready_flag` rises at that point.
- R6: With `nine_bit_en`=1, the frame is 9 bits long, and the ninth bit sent is `wr_bit9` captured with the word. With `nine_bit_en`=0, the frame is 8 bits long.
- R7: `irq_wake` = `ready_flag` AND `ready_int_en`.
- R8: `ext_clk_fall`=0 makes rising external edges active; `ext_clk_fall`=1 makes falling edges active.
- R9: `port_en`=0 clears the holding stage, the shifter and the bit count: `shreg_empty`=1, `ser_dout`=1, and no word is pending.
- R10: During reset, `ser_dout`=1 and `shreg_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| port_en | input | 1 | Serial port enable; 0 clears all transmit state |
| sync_mode | input | 1 | Synchronous mode select |
| clk_is_master | input | 1 | 1 = internal clock source; must be 0 to transmit |
| tx_en | input | 1 | Transmit enable |
| rx_one_en | input | 1 | Single receive enable; must be 0 to transmit |
| rx_cont_en | input | 1 | Continuous receive enable; must be 0 to transmit |
| nine_bit_en | input | 1 | 9-bit frame select |
| ext_clk_fall | input | 1 | Active external edge: 0 rising, 1 falling |
| ready_int_en | input | 1 | Enables the ready flag onto irq_wake |
| wr_valid | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Word to send |
| wr_bit9 | input | 1 | Ninth bit, latched with the word |
| ext_sclk | input | 1 | Externally supplied shift clock |
| ser_dout | output | 1 | Serial data output |
| shreg_empty | output | 1 | 1 when no bits remain in the shifter |
| ready_flag | output | 1 | 1 when the holding stage can accept a word |
| irq_wake | output | 1 | Interrupt / wake request |

## Verification
The bench goes after the hand-off of a queued word. It writes a second word while a frame is shifting and checks that the ready flag stays low until the first frame's last edge has passed. A design that raised the flag when the word entered the holding stage would invite an overrun, and a third write then tests that the pending word survives. Mode gating is tested by toggling the clock with the clock source set to master; a design that ignored the mode bits would send bits it must not send. A 9-bit frame, a falling-edge clock and a port disable in the middle of a frame check the frame length, the edge select, and a clear that must leave no stale word behind.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic              ninth;
        logic [DATA_W-1:0] data;
    } tx_word_t;

    typedef struct packed {
        logic port_on;
        logic sync_sel;
        logic clk_src_int;
        logic tx_on;
        logic rx_single;
        logic rx_cont;
    } tx_ctrl_t;

    function automatic logic slave_tx_allowed(tx_ctrl_t c);
        return c.port_on & c.sync_sel & ~c.clk_src_int & c.tx_on
               & ~c.rx_single & ~c.rx_cont;
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(logic nine);
        return nine ? CNT_W'(FRAME_W) : CNT_W'(DATA_W);
    endfunction

endpackage

// File: rtl/sync_tx_edge.sv
module sync_tx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic use_fall,
    output logic step
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;
    logic                   now_lvl;

    assign now_lvl = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], pin};
            prev  <= now_lvl;
        end
    end

    always_comb begin
        if (use_fall) step = prev & ~now_lvl;
        else          step = now_lvl & ~prev;
    end
endmodule

// File: rtl/sync_tx_hold.sv
module sync_tx_hold
    import sync_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     wr,
    input  tx_word_t wr_word,
    input  logic     take,
    output logic     valid,
    output tx_word_t word
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid <= 1'b0;
            word  <= '0;
        end else if (take) begin
            valid <= 1'b0;
        end else if (wr && !valid) begin
            valid <= 1'b1;
            word  <= wr_word;
        end
    end

    // R4: a write into a full holding stage changes nothing
    a_r4_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (valid && wr && !take && !clr) |=> (valid && $stable(word)));
endmodule

// File: rtl/sync_tx_shift.sv
module sync_tx_shift
    import sync_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     load,
    input  tx_word_t word,
    input  logic     nine,
    input  logic     adv,
    output logic     dout,
    output logic     empty
);
    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   left;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sr   <= '1;
            left <= '0;
        end else if (load) begin
            sr   <= {word.ninth, word.data};
            left <= frame_len(nine);
        end else if (adv && left != '0) begin
            left <= left - 1'b1;
            if (left != CNT_W'(1)) sr <= {1'b1, sr[FRAME_W-1:1]};
        end
    end

    assign dout  = sr[0];
    assign empty = (left == '0);

    // R3: without a clock edge or a load the line and the count hold
    a_r3_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load && !clr) |=> ($stable(sr) && $stable(left)));
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
    import sync_tx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              clk_is_master,
    input  logic              tx_en,
    input  logic              rx_one_en,
    input  logic              rx_cont_en,
    input  logic              nine_bit_en,
    input  logic              ext_clk_fall,
    input  logic              ready_int_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              ext_sclk,
    output logic              ser_dout,
    output logic              shreg_empty,
    output logic              ready_flag,
    output logic              irq_wake
);
    tx_ctrl_t ctrl;
    tx_word_t in_word;
    tx_word_t held;
    logic     active;
    logic     hold_valid;
    logic     edge_seen;
    logic     move;

    assign ctrl    = '{port_on: port_en, sync_sel: sync_mode,
                       clk_src_int: clk_is_master, tx_on: tx_en,
                       rx_single: rx_one_en, rx_cont: rx_cont_en};
    assign active  = slave_tx_allowed(ctrl);
    assign in_word = '{ninth: wr_bit9, data: wr_data};
    assign move    = active & hold_valid & shreg_empty;

    sync_tx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_sclk),
        .use_fall (ext_clk_fall),
        .step     (edge_seen)
    );

    sync_tx_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .clr     (~port_en),
        .wr      (wr_valid & active),
        .wr_word (in_word),
        .take    (move),
        .valid   (hold_valid),
        .word    (held)
    );

    sync_tx_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .clr   (~port_en),
        .load  (move),
        .word  (held),
        .nine  (nine_bit_en),
        .adv   (edge_seen & active),
        .dout  (ser_dout),
        .empty (shreg_empty)
    );

    assign ready_flag = active & ~hold_valid;
    assign irq_wake   = ready_flag & ready_int_en;

    // R2: a pending word enters an idle shifter on the next edge
    a_r2_idle_load: assert property (@(posedge clk) disable iff (rst)
        (active && shreg_empty && hold_valid) |=> (!shreg_empty && !hold_valid));

    // R9: port disable empties both stages and idles the line high
    a_r9_port_clear: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> (shreg_empty && !hold_valid && ser_dout));

    // R7: the wake line needs its enable and free space
    a_r7_wake_gate: assert property (@(posedge clk) disable iff (rst)
        irq_wake |-> (ready_int_en && !hold_valid));

    // R5: while a word waits behind a busy shifter, the flag stays low
    a_r5_flag_low_queued: assert property (@(posedge clk) disable iff (rst)
        (hold_valid && !shreg_empty && !edge_seen) |=> !ready_flag);
endmodule

// File: tb/sync_slave_tx_bench.sv
module sync_slave_tx_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic port_en, sync_mode, clk_is_master, tx_en, rx_one_en, rx_cont_en;
    logic nine_bit_en, ext_clk_fall, ready_int_en, wr_valid, wr_bit9, ext_sclk;
    logic [7:0] wr_data;
    logic ser_dout, shreg_empty, ready_flag, irq_wake;

    int n_run  = 0;
    int n_fail = 0;

    // reference model state
    bit       m_bits[$];
    bit       m_dout;
    bit       m_hold_v;
    bit [8:0] m_hold;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_slave_tx u_sync_slave_tx (
        .clk(clk), .rst(rst), .port_en(port_en), .sync_mode(sync_mode),
        .clk_is_master(clk_is_master), .tx_en(tx_en), .rx_one_en(rx_one_en),
        .rx_cont_en(rx_cont_en), .nine_bit_en(nine_bit_en),
        .ext_clk_fall(ext_clk_fall), .ready_int_en(ready_int_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_bit9(wr_bit9),
        .ext_sclk(ext_sclk), .ser_dout(ser_dout), .shreg_empty(shreg_empty),
        .ready_flag(ready_flag), .irq_wake(irq_wake)
    );

    function automatic bit m_active();
        return port_en && sync_mode && !clk_is_master && tx_en && !rx_one_en && !rx_cont_en;
    endfunction

    function automatic void m_try_load();
        if (m_active() && m_hold_v && m_bits.size() == 0) begin
            int n = nine_bit_en ? 9 : 8;
            for (int i = 0; i < n; i++) m_bits.push_back(m_hold[i]);
            m_hold_v = 0;
            m_dout   = m_bits[0];
        end
    endfunction

    function automatic void m_write(bit [7:0] d, bit b9);
        if (m_active() && !m_hold_v) begin
            m_hold_v = 1;
            m_hold   = {b9, d};
        end
        m_try_load();
    endfunction

    function automatic void m_edge();
        if (m_active() && m_bits.size() > 0) begin
            void'(m_bits.pop_front());
            if (m_bits.size() > 0) m_dout = m_bits[0];
        end
        m_try_load();
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        bit f;
        f = m_active() && !m_hold_v;
        chk({tag, " ser_dout"},    ser_dout,    m_dout);
        chk({tag, " shreg_empty"}, shreg_empty, m_bits.size() == 0);
        chk({tag, " ready_flag R5"}, ready_flag, f);
        chk({tag, " irq_wake R7"}, irq_wake,    f && ready_int_en);
    endtask

    task automatic do_write(string tag, bit [7:0] d, bit b9);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_bit9 = b9;
        @(negedge clk);
        wr_valid = 1'b0;
        m_write(d, b9);
        repeat (3) @(negedge clk);
        compare_all(tag);
    endtask

    task automatic pulse(string tag);
        @(negedge clk);
        ext_sclk = ext_clk_fall ? 1'b0 : 1'b1;
        repeat (5) @(negedge clk);
        m_edge();
        compare_all(tag);
        ext_sclk = ext_clk_fall ? 1'b1 : 1'b0;
        repeat (5) @(negedge clk);
        compare_all({tag, " idle half"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        port_en = 1; sync_mode = 1; clk_is_master = 0; tx_en = 1;
        rx_one_en = 0; rx_cont_en = 0; nine_bit_en = 0; ext_clk_fall = 0;
        ready_int_en = 0; wr_valid = 0; wr_data = '0; wr_bit9 = 0; ext_sclk = 0;
        m_dout = 1; m_hold_v = 0; m_hold = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset dout", ser_dout, 1'b1);
        chk("R10 reset empty", shreg_empty, 1'b1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        compare_all("R5 idle after reset");

        // R2: exact timing of a write into an idle transmitter
        wr_valid = 1'b1; wr_data = 8'hA5; wr_bit9 = 0;
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R2 held one cycle, empty", shreg_empty, 1'b1);
        chk("R2 held one cycle, flag", ready_flag, 1'b0);
        @(negedge clk);
        chk("R2 loaded, empty", shreg_empty, 1'b0);
        chk("R2 loaded, bit0", ser_dout, 1'b1);
        chk("R2 loaded, flag", ready_flag, 1'b1);
        m_write(8'hA5, 1'b0);

        // R4: queued word, then a write into a full holding stage
        do_write("R4 queue 3C", 8'h3C, 1'b0);
        do_write("R4 ignored FF", 8'hFF, 1'b0);

        // R1: clock edges with master clock source selected do nothing
        clk_is_master = 1'b1;
        pulse("R1 master blocked");
        pulse("R1 master blocked 2");
        clk_is_master = 1'b0;
        repeat (2) @(negedge clk);
        compare_all("R1 restored");

        // R3 / R5: shift A5 out, hand-off of 3C, shift 3C out
        for (int i = 0; i < 16; i++) pulse("R3 shift A5/3C");

        // R6: nine-bit frames
        nine_bit_en = 1'b1;
        do_write("R6 write 00+1", 8'h00, 1'b1);
        for (int i = 0; i < 9; i++) pulse("R6 nine bit one");
        do_write("R6 write FF+0", 8'hFF, 1'b0);
        for (int i = 0; i < 9; i++) pulse("R6 nine bit zero");
        nine_bit_en = 1'b0;

        // R7: wake output gated by enable
        ready_int_en = 1'b1;
        do_write("R7 write 81", 8'h81, 1'b0);
        do_write("R7 queued 7E", 8'h7E, 1'b0);
        for (int i = 0; i < 16; i++) pulse("R7 drain");

        // R9: port disable mid-frame, with a word pending
        do_write("R9 write 55", 8'h55, 1'b0);
        do_write("R9 pend 0F", 8'h0F, 1'b0);
        pulse("R9 partial");
        pulse("R9 partial 2");
        @(negedge clk);
        port_en = 1'b0;
        repeat (2) @(negedge clk);
        m_bits.delete(); m_hold_v = 0; m_dout = 1;
        compare_all("R9 cleared");
        port_en = 1'b1;
        repeat (3) @(negedge clk);
        compare_all("R9 re-enabled no stale word");

        // R8: falling edge is active
        ext_clk_fall = 1'b1; ext_sclk = 1'b1;
        repeat (5) @(negedge clk);
        compare_all("R8 switch");
        do_write("R8 write 96", 8'h96, 1'b0);
        for (int i = 0; i < 8; i++) pulse("R8 falling shift");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule